// File: doc/BRIEF.md
# DDR command sequencer with refresh

This block is the central control state machine of a DDR SDRAM controller. After reset it waits a stabilization count and then runs a fixed power-up sequence that precharges all banks, programs the extended and base mode registers, and issues two auto refreshes. Only after that sequence does it accept user traffic.

User requests sit in an external first-word-fall-through queue. Each entry carries a read/write flag, a bank, a row and a column. When the queue is not empty, the sequencer pops the head entry and looks up the open row of the target bank. It then issues either a READ or WRITE directly, an ACTIVE followed by the access, or a PRECHARGE, ACTIVE and access. A periodic refresh timer raises a refresh request, and that request is served before any queued request.

For every access the block produces datapath enable strobes. These are placed from the write latency or from the CAS latency, and they last for the two controller cycles of a burst of four.

Top module: `ddr_cmd_seq`

## Requirements
- R1: While rst_ni is low the command bus shows NOP (111), fifo_pop_o is low and both strobes are low. No entry is popped and no user command is issued before the power-up sequence ends. The first command comes no earlier than T_INIT cycles after reset release.
- R2: The power-up sequence runs in this order:
  - PRECHARGE with address bit 10 set, then T_RP cycles later LOAD MODE with bank 01 and address 0.
  - T_MRD later, LOAD MODE with bank 00 and address (1<<8)|(CAS_LAT<<4)|2.
  - T_MRD later, PRECHARGE with bit 10 set.
  - T_RP later, AUTO REFRESH, and T_RFC later a second AUTO REFRESH.
  - T_RFC later, LOAD MODE with bank 00 and address (CAS_LAT<<4)|2.
  - The next command comes at least T_MRD after that final LOAD MODE.
- R3: An entry is popped only while fifo_empty_i is low. Entries are served in queue order. Each READ/WRITE carries the entry's bank and its column on the low address bits with bit 10 clear, and WRITE is used when fifo_wr_i is 1.
- R4: A request to a bank with no open row gets ACTIVE with the entry's row. Exactly T_RCD cycles later the READ/WRITE follows to the same bank.
- R5: A request to a bank whose open row differs gets PRECHARGE with address bit 10 clear on that bank. Exactly T_RP cycles later it gets ACTIVE on the same bank.
- R6: A request to the row already open in its bank gets READ/WRITE with no ACTIVE or PRECHARGE. Two READ/WRITE commands are at least 2 cycles apart.
- R7: A refresh is a PRECHARGE with bit 10 set, then exactly T_RP cycles later an AUTO REFRESH. No command follows within T_RFC cycles of any AUTO REFRESH.
- R8: With an empty queue, AUTO REFRESH recurs exactly every T_REF cycles. While a refresh is pending no entry is popped.
- R9: A WRITE on the bus in cycle t raises wr_en_o in cycles t+1 and t+2 only.
- R10: A READ on the bus in cycle t raises rd_en_o in cycles t+CAS_LAT and t+CAS_LAT+1 only.
- R11: Commands on {ras_n, cas_n, we_n} use these encodings: ACTIVE 011, READ 101, WRITE 100, PRECHARGE 010, AUTO REFRESH 001, LOAD MODE 000, NOP 111. Code 110 never appears, and LOAD MODE never appears after power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | controller clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| fifo_empty_i | input | 1 | request queue empty |
| fifo_wr_i | input | 1 | head entry is a write (1) or read (0) |
| fifo_bank_i | input | BANK_W | head entry bank |
| fifo_row_i | input | ROW_W | head entry row |
| fifo_col_i | input | COL_W | head entry column |
| fifo_pop_o | output | 1 | pops the head entry at this clock edge |
| ddr_ras_n_o | output | 1 | row strobe, active low |
| ddr_cas_n_o | output | 1 | column strobe, active low |
| ddr_we_n_o | output | 1 | write enable, active low |
| ddr_ba_o | output | BANK_W | bank address |
| ddr_addr_o | output | ROW_W | row/column/mode address |
| wr_en_o | output | 1 | write datapath enable |
| rd_en_o | output | 1 | read datapath enable |

## Verification
The bench builds the block with four banks and a short 16-cycle stabilization count. It uses T_RP=2, T_MRD=2, T_RCD=3, T_RFC=7, CAS latency 3 and a 150-cycle refresh interval. With these values the whole power-up sequence and several idle refresh periods fit in a few hundred cycles. A sweep over every bank and both directions, covering miss, hit and conflict, plus a slow trickle of requests, then crosses refresh boundaries many times. Every command is judged against a bank/row model the bench keeps from the bus itself, and strobe cycles are derived from the command cycle.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

  typedef enum logic [2:0] {
    CMD_LMR = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_NOP = 3'b111
  } ddr_cmd_e;

  typedef enum logic [2:0] {
    ST_INIT_WAIT,
    ST_INIT_SEQ,
    ST_IDLE,
    ST_ACT,
    ST_RW,
    ST_REF
  } seq_st_e;

  localparam int BURST_CYC = 2;  // burst of 4 at double rate
  localparam int WR_LAT    = 1;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_ref_timer.sv
module ddr_ref_timer #(
  parameter int T_REF = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = $clog2(T_REF + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (en_i) begin
        if (cnt_q == CW'(T_REF - 1)) begin
          cnt_q  <= '0;
          tick_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ddr_bank_rows.sv
module ddr_bank_rows #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          act_i,
  input  logic                          pre_i,
  input  logic                          pre_all_i,
  input  logic [BANK_W-1:0]             bank_i,
  input  logic [ROW_W-1:0]              row_i,
  output logic [(1<<BANK_W)-1:0]        open_o,
  output logic [(1<<BANK_W)-1:0][ROW_W-1:0] rows_o
);
  localparam int NB = 1 << BANK_W;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic sel;
    assign sel = (bank_i == BANK_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_o[b] <= 1'b0;
        rows_o[b] <= '0;
      end else if (pre_all_i || (pre_i && sel)) begin
        open_o[b] <= 1'b0;
      end else if (act_i && sel) begin
        open_o[b] <= 1'b1;
        rows_o[b] <= row_i;
      end
    end
  end
endmodule

// File: rtl/ddr_dp_strobe.sv
module ddr_dp_strobe #(
  parameter int LAT   = 3,
  parameter int BURST = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  output logic en_o
);
  localparam int DEPTH = LAT + BURST - 1;

  logic [DEPTH-1:0] dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dly_q <= '0;
    else         dly_q <= {dly_q[DEPTH-2:0], issue_i};
  end

  // window of BURST taps ending at the deepest stage
  assign en_o = |dly_q[DEPTH-1:LAT-1];
endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
  import ddr_seq_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 10,
  parameter int T_INIT  = 200,
  parameter int T_RP    = 3,
  parameter int T_RCD   = 3,
  parameter int T_RFC   = 10,
  parameter int T_MRD   = 2,
  parameter int T_REF   = 780,
  parameter int CAS_LAT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_empty_i,
  input  logic              fifo_wr_i,
  input  logic [BANK_W-1:0] fifo_bank_i,
  input  logic [ROW_W-1:0]  fifo_row_i,
  input  logic [COL_W-1:0]  fifo_col_i,
  output logic              fifo_pop_o,
  output logic              ddr_ras_n_o,
  output logic              ddr_cas_n_o,
  output logic              ddr_we_n_o,
  output logic [BANK_W-1:0] ddr_ba_o,
  output logic [ROW_W-1:0]  ddr_addr_o,
  output logic              wr_en_o,
  output logic              rd_en_o
);
  localparam int NB     = 1 << BANK_W;
  localparam int MAX_T  = max_of(max_of(T_INIT, T_RFC), max_of(max_of(T_RP, T_RCD), T_MRD));
  localparam int CNT_W  = $clog2(MAX_T + 1) + 1;
  localparam int AP_BIT = 10;

  seq_st_e           state_q, state_d;
  logic [2:0]        step_q, step_d;
  logic [CNT_W-1:0]  wait_q, wait_d;
  ddr_cmd_e          cmd_q, cmd_d;
  logic [BANK_W-1:0] ba_q, ba_d;
  logic [ROW_W-1:0]  addr_q, addr_d;
  logic              init_done_q, init_done_d;
  logic              ref_pend_q, ref_clr, ref_tick;
  logic              latch_req;
  logic              req_wr_q;
  logic [BANK_W-1:0] req_bank_q;
  logic [ROW_W-1:0]  req_row_q;
  logic [COL_W-1:0]  req_col_q;

  logic [NB-1:0]            bank_open;
  logic [NB-1:0][ROW_W-1:0] bank_row;
  logic                     head_open, head_hit, ready;

  function automatic logic [ROW_W-1:0] mode_word(input logic dll_rst);
    return ROW_W'({dll_rst, 1'b0, 3'(CAS_LAT), 1'b0, 3'b010});
  endfunction

  assign head_open  = bank_open[fifo_bank_i];
  assign head_hit   = head_open && (bank_row[fifo_bank_i] == fifo_row_i);
  assign ready      = (state_q == ST_IDLE) && (wait_q == '0);
  assign fifo_pop_o = ready && !ref_pend_q && !fifo_empty_i;

  always_comb begin
    state_d     = state_q;
    step_d      = step_q;
    wait_d      = wait_q;
    cmd_d       = CMD_NOP;
    ba_d        = '0;
    addr_d      = '0;
    init_done_d = init_done_q;
    ref_clr     = 1'b0;
    latch_req   = 1'b0;
    if (wait_q != '0) begin
      wait_d = wait_q - 1'b1;
    end else begin
      unique case (state_q)
        ST_INIT_WAIT: begin
          state_d = ST_INIT_SEQ;
          step_d  = '0;
        end
        ST_INIT_SEQ: begin
          step_d = step_q + 1'b1;
          case (step_q)
            3'd0, 3'd3: begin
              cmd_d          = CMD_PRE;
              addr_d[AP_BIT] = 1'b1;
              wait_d         = CNT_W'(T_RP - 1);
            end
            3'd1: begin
              cmd_d  = CMD_LMR;
              ba_d   = BANK_W'(1);
              wait_d = CNT_W'(T_MRD - 1);
            end
            3'd2: begin
              cmd_d  = CMD_LMR;
              addr_d = mode_word(1'b1);
              wait_d = CNT_W'(T_MRD - 1);
            end
            3'd4, 3'd5: begin
              cmd_d  = CMD_REF;
              wait_d = CNT_W'(T_RFC - 1);
            end
            default: begin
              cmd_d       = CMD_LMR;
              addr_d      = mode_word(1'b0);
              wait_d      = CNT_W'(T_MRD - 1);
              state_d     = ST_IDLE;
              init_done_d = 1'b1;
            end
          endcase
        end
        ST_IDLE: begin
          if (ref_pend_q) begin
            cmd_d          = CMD_PRE;
            addr_d[AP_BIT] = 1'b1;
            wait_d         = CNT_W'(T_RP - 1);
            state_d        = ST_REF;
          end else if (!fifo_empty_i) begin
            latch_req = 1'b1;
            ba_d      = fifo_bank_i;
            if (head_hit) begin
              cmd_d  = fifo_wr_i ? CMD_WR : CMD_RD;
              addr_d = ROW_W'(fifo_col_i);
              wait_d = CNT_W'(BURST_CYC - 1);
            end else if (head_open) begin
              cmd_d   = CMD_PRE;
              wait_d  = CNT_W'(T_RP - 1);
              state_d = ST_ACT;
            end else begin
              cmd_d   = CMD_ACT;
              addr_d  = fifo_row_i;
              wait_d  = CNT_W'(T_RCD - 1);
              state_d = ST_RW;
            end
          end
        end
        ST_ACT: begin
          cmd_d   = CMD_ACT;
          ba_d    = req_bank_q;
          addr_d  = req_row_q;
          wait_d  = CNT_W'(T_RCD - 1);
          state_d = ST_RW;
        end
        ST_RW: begin
          cmd_d   = req_wr_q ? CMD_WR : CMD_RD;
          ba_d    = req_bank_q;
          addr_d  = ROW_W'(req_col_q);
          wait_d  = CNT_W'(BURST_CYC - 1);
          state_d = ST_IDLE;
        end
        ST_REF: begin
          cmd_d   = CMD_REF;
          wait_d  = CNT_W'(T_RFC - 1);
          ref_clr = 1'b1;
          state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_INIT_WAIT;
      step_q      <= '0;
      wait_q      <= CNT_W'(T_INIT);
      cmd_q       <= CMD_NOP;
      ba_q        <= '0;
      addr_q      <= '0;
      init_done_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      step_q      <= step_d;
      wait_q      <= wait_d;
      cmd_q       <= cmd_d;
      ba_q        <= ba_d;
      addr_q      <= addr_d;
      init_done_q <= init_done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_wr_q   <= 1'b0;
      req_bank_q <= '0;
      req_row_q  <= '0;
      req_col_q  <= '0;
    end else if (latch_req) begin
      req_wr_q   <= fifo_wr_i;
      req_bank_q <= fifo_bank_i;
      req_row_q  <= fifo_row_i;
      req_col_q  <= fifo_col_i;
    end
  end

  // a tick while a refresh is being issued wins over the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ref_pend_q <= 1'b0;
    else if (ref_tick) ref_pend_q <= 1'b1;
    else if (ref_clr)  ref_pend_q <= 1'b0;
  end

  ddr_ref_timer #(.T_REF(T_REF)) u_ref_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (init_done_q),
    .tick_o (ref_tick)
  );

  // tracker follows the registered bus; decisions trail commands by at least one cycle
  ddr_bank_rows #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_bank_rows (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (cmd_q == CMD_ACT),
    .pre_i     (cmd_q == CMD_PRE),
    .pre_all_i ((cmd_q == CMD_PRE) && addr_q[AP_BIT]),
    .bank_i    (ba_q),
    .row_i     (addr_q),
    .open_o    (bank_open),
    .rows_o    (bank_row)
  );

  ddr_dp_strobe #(.LAT(WR_LAT), .BURST(BURST_CYC)) u_wr_strobe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (cmd_q == CMD_WR),
    .en_o    (wr_en_o)
  );

  ddr_dp_strobe #(.LAT(CAS_LAT), .BURST(BURST_CYC)) u_rd_strobe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (cmd_q == CMD_RD),
    .en_o    (rd_en_o)
  );

  assign ddr_ras_n_o = cmd_q[2];
  assign ddr_cas_n_o = cmd_q[1];
  assign ddr_we_n_o  = cmd_q[0];
  assign ddr_ba_o    = ba_q;
  assign ddr_addr_o  = addr_q;

endmodule

// File: rtl/ddr_cmd_seq_chk.sv
module ddr_cmd_seq_chk
  import ddr_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] cmd_i,
  input logic       pop_i,
  input logic       empty_i,
  input logic       wr_en_i,
  input logic       init_done_i,
  input logic       ref_pend_i
);
  AST_POP_NEEDS_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni) pop_i |-> !empty_i); // R3
  AST_NO_POP_IN_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni) !init_done_i |-> !pop_i); // R1
  AST_REFRESH_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni) ref_pend_i |-> !pop_i); // R8
  AST_REF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) (cmd_i == CMD_REF) |=> (cmd_i == CMD_NOP)); // R7
  AST_WR_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni) (cmd_i == CMD_WR) |=> wr_en_i); // R9
  AST_NO_BAD_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni) cmd_i != 3'b110); // R11
  AST_NO_LMR_AFTER_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni) $past(init_done_i) |-> (cmd_i != CMD_LMR)); // R11
endmodule

bind ddr_cmd_seq ddr_cmd_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_i       (cmd_q),
  .pop_i       (fifo_pop_o),
  .empty_i     (fifo_empty_i),
  .wr_en_i     (wr_en_o),
  .init_done_i (init_done_q),
  .ref_pend_i  (ref_pend_q)
);

// File: tb/ddr_cmd_seq_bench.sv
`timescale 1ns/1ps
module ddr_cmd_seq_bench;
  localparam int BANK_W = 2, ROW_W = 12, COL_W = 8;
  localparam int T_INIT = 16, T_RP = 2, T_RCD = 3, T_RFC = 7, T_MRD = 2, T_REF = 150, CL = 3;
  localparam logic [2:0] C_LMR = 3'b000, C_REF = 3'b001, C_PRE = 3'b010, C_ACT = 3'b011,
                         C_WR = 3'b100, C_RD = 3'b101, C_NOP = 3'b111;

  logic clk_i = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  int cyc = 0;
  int wr_ptr = 0, rd_ptr = 0, sv_ptr = 0;
  bit m_wr[256];
  int m_bank[256], m_row[256], m_col[256];

  logic              fifo_empty, fifo_pop, ras_n, cas_n, we_n, wr_en, rd_en;
  logic [BANK_W-1:0] ba;
  logic [ROW_W-1:0]  addr;

  assign fifo_empty = (rd_ptr == wr_ptr);

  ddr_cmd_seq #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .T_INIT(T_INIT), .T_RP(T_RP),
    .T_RCD(T_RCD), .T_RFC(T_RFC), .T_MRD(T_MRD), .T_REF(T_REF), .CAS_LAT(CL)
  ) u_ddr_cmd_seq (
    .clk_i(clk_i), .rst_ni(rst_n), .fifo_empty_i(fifo_empty),
    .fifo_wr_i(m_wr[rd_ptr % 256]), .fifo_bank_i(BANK_W'(m_bank[rd_ptr % 256])),
    .fifo_row_i(ROW_W'(m_row[rd_ptr % 256])), .fifo_col_i(COL_W'(m_col[rd_ptr % 256])),
    .fifo_pop_o(fifo_pop), .ddr_ras_n_o(ras_n), .ddr_cas_n_o(cas_n), .ddr_we_n_o(we_n),
    .ddr_ba_o(ba), .ddr_addr_o(addr), .wr_en_o(wr_en), .rd_en_o(rd_en)
  );

  always @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin rd_ptr <= 0; cyc <= 0; end
    else begin
      cyc <= cyc + 1;
      if (fifo_pop) rd_ptr <= rd_ptr + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic push(input bit w, input int b, input int r, input int c);
    @(negedge clk_i);
    m_wr[wr_ptr % 256] = w; m_bank[wr_ptr % 256] = b;
    m_row[wr_ptr % 256] = r; m_col[wr_ptr % 256] = c;
    wr_ptr++;
  endtask

  // bus monitor with its own bank model
  logic [2:0] cmd, last_cmd;
  int last_cyc = 0, last_ba = 0, ncmd = 0, gap, hb, hr, hc;
  bit last_ap, hw, open_m[4];
  int row_m[4];
  bit exp_rd[64], exp_wr[64];
  bit idle_win = 0, ref_prev_ok = 0;
  int ref_prev = 0, idle_refs = 0;
  logic [2:0] ic;
  int iba, iad, igap;

  assign cmd = {ras_n, cas_n, we_n};

  always @(negedge clk_i) begin
    if (rst_n) begin
      check(rd_en == exp_rd[cyc % 64], "R10", int'(rd_en), int'(exp_rd[cyc % 64]));
      check(wr_en == exp_wr[cyc % 64], "R9", int'(wr_en), int'(exp_wr[cyc % 64]));
      exp_rd[cyc % 64] = 0; exp_wr[cyc % 64] = 0;
      if (fifo_pop) begin
        check(ncmd >= 7, "R1", ncmd, 7);
        check(!fifo_empty, "R3", int'(fifo_empty), 0);
      end
      if (cmd != C_NOP) begin
        gap = cyc - last_cyc;
        if (ncmd < 7) begin
          case (ncmd)
            0: begin ic = C_PRE; iba = -1; iad = -1; igap = 0; end
            1: begin ic = C_LMR; iba = 1; iad = 0; igap = T_RP; end
            2: begin ic = C_LMR; iba = 0; iad = 256 + CL * 16 + 2; igap = T_MRD; end
            3: begin ic = C_PRE; iba = -1; iad = -1; igap = T_MRD; end
            4: begin ic = C_REF; iba = -1; iad = -2; igap = T_RP; end
            5: begin ic = C_REF; iba = -1; iad = -2; igap = T_RFC; end
            default: begin ic = C_LMR; iba = 0; iad = CL * 16 + 2; igap = T_RFC; end
          endcase
          check(cmd == ic, "R2", int'(cmd), int'(ic));
          if (ncmd == 0) check(cyc >= T_INIT, "R1", cyc, T_INIT);
          else check(gap == igap, "R2", gap, igap);
          if (iba >= 0) check(int'(ba) == iba, "R2", int'(ba), iba);
          if (iad >= 0) check(int'(addr) == iad, "R2", int'(addr), iad);
          if (iad == -1) check(addr[10], "R2", int'(addr[10]), 1);
        end else begin
          case (last_cmd)
            C_ACT: check((cmd == C_RD || cmd == C_WR) && gap == T_RCD && int'(ba) == last_ba,
                         "R4", gap, T_RCD);
            C_PRE: if (last_ap) check(cmd == C_REF && gap == T_RP, "R7", gap, T_RP);
                   else check(cmd == C_ACT && gap == T_RP && int'(ba) == last_ba, "R5", gap, T_RP);
            C_REF: check(gap >= T_RFC, "R7", gap, T_RFC);
            C_RD, C_WR: check(gap >= 2, "R6", gap, 2);
            default: check(gap >= T_MRD, "R2", gap, T_MRD);
          endcase
          hb = m_bank[sv_ptr % 256]; hr = m_row[sv_ptr % 256];
          hc = m_col[sv_ptr % 256]; hw = m_wr[sv_ptr % 256];
          case (cmd)
            C_ACT: begin
              check(sv_ptr < wr_ptr, "R3", sv_ptr, wr_ptr);
              check(int'(ba) == hb && int'(addr) == hr && !open_m[ba], "R4", int'(addr), hr);
              open_m[ba] = 1; row_m[ba] = int'(addr);
            end
            C_PRE: begin
              if (addr[10]) begin
                for (int b = 0; b < 4; b++) open_m[b] = 0;
              end else begin
                check(sv_ptr < wr_ptr, "R3", sv_ptr, wr_ptr);
                check(int'(ba) == hb && open_m[ba] && row_m[ba] != hr, "R5", int'(ba), hb);
                open_m[ba] = 0;
              end
            end
            C_RD, C_WR: begin
              check(sv_ptr < wr_ptr, "R3", sv_ptr, wr_ptr);
              check(int'(ba) == hb && int'(addr) == hc && ((cmd == C_WR) == hw),
                    "R3", int'(addr), hc);
              check(open_m[ba] && row_m[ba] == hr, "R6", row_m[ba], hr);
              sv_ptr++;
              if (cmd == C_RD) begin exp_rd[(cyc + CL) % 64] = 1; exp_rd[(cyc + CL + 1) % 64] = 1; end
              else begin exp_wr[(cyc + 1) % 64] = 1; exp_wr[(cyc + 2) % 64] = 1; end
            end
            C_REF: begin
              if (idle_win && ref_prev_ok) begin
                check(cyc - ref_prev == T_REF, "R8", cyc - ref_prev, T_REF);
                idle_refs++;
              end
              ref_prev = cyc; ref_prev_ok = idle_win;
            end
            default: check(1'b0, "R11", int'(cmd), int'(C_NOP));
          endcase
        end
        last_cmd = cmd; last_cyc = cyc; last_ba = int'(ba); last_ap = addr[10];
        ncmd++;
      end
    end
  end

  task automatic drain();
    for (int i = 0; i < 5000 && sv_ptr != wr_ptr; i++) @(negedge clk_i);
    repeat (12) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(cmd == C_NOP, "R1", int'(cmd), int'(C_NOP));
    check(!fifo_pop && !rd_en && !wr_en, "R1", int'({fifo_pop, rd_en, wr_en}), 0);
    rst_n = 1'b1;
    // empty queue: only refreshes, fixed period
    idle_win = 1;
    repeat (T_INIT + 80 + 3 * T_REF) @(negedge clk_i);
    idle_win = 0;
    check(ncmd >= 7, "R2", ncmd, 7);
    check(idle_refs >= 2, "R8", idle_refs, 2);
    check(sv_ptr == 0, "R3", sv_ptr, 0);
    // sweep: miss, hit, conflict, hit per bank and direction
    for (int w = 0; w < 2; w++)
      for (int b = 0; b < 4; b++) begin
        push(w[0], b, 5, b * 16 + w * 8);
        push(w[0], b, 5, b * 16 + w * 8 + 4);
        push(!w[0], b, 9, b * 16 + 64);
        push(w[0], b, 9, b * 16 + 68);
      end
    drain();
    // interleaved banks with rotating rows
    for (int k = 0; k < 24; k++) push(k[0], k % 4, (k / 4) % 3, (k * 4) % 256);
    drain();
    // slow trickle crossing refresh boundaries
    for (int k = 0; k < 20; k++) begin
      push(k[1], (k * 3) % 4, k % 2 ? 7 : 11, (k * 8) % 256);
      repeat (37) @(negedge clk_i);
    end
    drain();
    check(sv_ptr == wr_ptr, "R3", sv_ptr, wr_ptr);
    check(rd_ptr == wr_ptr, "R3", rd_ptr, wr_ptr);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule